// File: doc/BRIEF.md
# Self-Correcting Latin-Square Check-Bit Encoder

This block computes the check bits of a single-error-correcting orthogonal Latin squares code for a data word of `M*M` bits. It also guards its own result. Two independent check-bit generators see the same word. The primary result goes through a parity checker. Because every data bit feeds an even number of checks, the XOR of all fault-free check bits is zero. A nonzero parity raises the error flag, and the flag switches the output over to the second generator's bits.

The parity is taken as two partial parities over disjoint halves of the check bits, and the flag is their XOR. A test input flips selected bits of the primary result. It stands in for a stuck-at or transient fault on a primary check bit. In normal use this input is tied to zero.

When `OUT_REG` is 1 (the default), the corrected check bits and the flag are registered and cleared by a synchronous active-high reset. When `OUT_REG` is 0, the block is purely combinational.

Top module: `ols_selfcorr_enc`

## Requirements
- R1: The word has K = M*M data bits and the block produces NCHK = 2*T*M check bits. With M=4 and T=1 this is 16 data bits and 8 check bits. Every data bit feeds exactly 2*T check bits, so a word with a single set bit yields exactly 2*T ones at the output.
- R2: Check bit i, for 0 <= i < M, is the XOR of data bits i*M through i*M+M-1.
- R3: Check bit M+j, for 0 <= j < M, is the XOR of data bits j, j+M, j+2M, ... j+(M-1)M.
- R4: With `flt_inj_i` zero, `err_o` is 0 and `chk_o` equals the code's check bits for any data word.
- R5: `err_o` equals the XOR of all primary check bits after injection. For a fault-free word this is the XOR of the bits of `flt_inj_i`: 1 when an odd number of primary bits are flipped.
- R6: When `err_o` is 1, `chk_o` carries the duplicate generator's bits. These equal the correct check bits, so a single flipped primary bit never reaches the output.
- R7: When an even, nonzero number of primary bits is flipped, `err_o` stays 0 and `chk_o` shows the flipped primary bits, which are the correct bits XOR `flt_inj_i`.
- R8: With `OUT_REG`=1, `chk_o` and `err_o` change one clock edge after the inputs. While `rst` is high at an edge, both are cleared to 0.
- R9: A primary bit stuck at the value it should already have raises no flag and leaves the output correct. A bit stuck at the opposite value raises `err_o` and is corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | K (16) | Data word to encode |
| flt_inj_i | input | NCHK (8) | Per-bit flip applied to the primary generator's result (fault emulation) |
| chk_o | output | NCHK (8) | Corrected check bits |
| err_o | output | 1 | Primary result failed the parity check |

## Verification
Detection and correction fall in the same cycle: the flag rises on exactly the edge at which the output must already carry the duplicate's bits. The bench provokes this in two ways. It flips each primary check bit in turn on random words. It also models stuck-at-0 and stuck-at-1 on every bit, flipping a bit only when the stuck value differs from the correct one. In each case it judges the flag and the full output word against the arithmetic golden code on that same sample. Even-weight flips show the opposite pairing: no flag, and a corrupted output whose value is predicted exactly.

// File: rtl/ols_pkg.sv
package ols_pkg;

  // Is data bit b a member of check j within Latin square s (m x m grid)?
  // s = 0: row groups, s = 1: column groups, s >= 2: shifted diagonals.
  function automatic logic ols_member(input int s, input int j, input int b, input int m);
    int r;
    int c;
    r = b / m;
    c = b % m;
    if (s == 0)      return (r == j);
    else if (s == 1) return (c == j);
    else             return (((c + (s - 1) * r) % m) == j);
  endfunction

endpackage

// File: rtl/ols_chk_gen.sv
module ols_chk_gen
  import ols_pkg::*;
#(
  parameter int M = 4,
  parameter int T = 1,
  localparam int K    = M * M,
  localparam int NCHK = 2 * T * M
) (
  input  logic [K-1:0]    data_i,
  output logic [NCHK-1:0] chk_o
);

  // Each check bit is an independent XOR tree; no gate is shared between
  // two checks because two data bits meet in at most one equation.
  for (genvar q = 0; q < NCHK; q++) begin : g_chk
    localparam int SQ  = q / M;
    localparam int IDX = q % M;
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int b = 0; b < K; b++) begin
        if (ols_member(SQ, IDX, b, M)) acc = acc ^ data_i[b];
      end
    end
    assign chk_o[q] = acc;
  end

endmodule

// File: rtl/ols_par_checker.sv
module ols_par_checker #(
  parameter int NCHK = 8,
  localparam int HALF = NCHK / 2
) (
  input  logic [NCHK-1:0] chk_i,
  output logic            err_o
);

  logic part_lo;
  logic part_hi;

  // Two disjoint partial parities; a fault-free word gives equal halves.
  assign part_lo = ^chk_i[HALF-1:0];
  assign part_hi = ^chk_i[NCHK-1:HALF];
  assign err_o   = part_lo ^ part_hi;

endmodule

// File: rtl/ols_out_stage.sv
module ols_out_stage #(
  parameter int NCHK    = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCHK-1:0] pri_i,
  input  logic [NCHK-1:0] dup_i,
  input  logic            sel_dup_i,
  output logic [NCHK-1:0] chk_o,
  output logic            err_o
);

  logic [NCHK-1:0] picked;

  for (genvar q = 0; q < NCHK; q++) begin : g_mux
    assign picked[q] = sel_dup_i ? dup_i[q] : pri_i[q];
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        chk_o <= '0;
        err_o <= 1'b0;
      end else begin
        chk_o <= picked;
        err_o <= sel_dup_i;
      end
    end
  end else begin : g_comb
    assign chk_o = picked;
    assign err_o = sel_dup_i;
  end

endmodule

// File: rtl/ols_selfcorr_enc.sv
module ols_selfcorr_enc #(
  parameter int M       = 4,
  parameter int T       = 1,
  parameter bit OUT_REG = 1'b1,
  localparam int K      = M * M,
  localparam int NCHK   = 2 * T * M
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [K-1:0]    data_i,
  input  logic [NCHK-1:0] flt_inj_i,
  output logic [NCHK-1:0] chk_o,
  output logic            err_o
);

  logic [NCHK-1:0] pri_raw;
  logic [NCHK-1:0] pri_chk;
  logic [NCHK-1:0] dup_chk;
  logic            par_err;

  ols_chk_gen #(.M(M), .T(T)) u_pri (
    .data_i (data_i),
    .chk_o  (pri_raw)
  );

  // Fault emulation point on the primary result only.
  assign pri_chk = pri_raw ^ flt_inj_i;

  ols_chk_gen #(.M(M), .T(T)) u_dup (
    .data_i (data_i),
    .chk_o  (dup_chk)
  );

  ols_par_checker #(.NCHK(NCHK)) u_par (
    .chk_i (pri_chk),
    .err_o (par_err)
  );

  ols_out_stage #(.NCHK(NCHK), .OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst       (rst),
    .pri_i     (pri_chk),
    .dup_i     (dup_chk),
    .sel_dup_i (par_err),
    .chk_o     (chk_o),
    .err_o     (err_o)
  );

endmodule

// File: rtl/ols_enc_sva.sv
module ols_enc_sva #(
  parameter int M       = 4,
  parameter int T       = 1,
  parameter bit OUT_REG = 1'b1,
  localparam int K      = M * M,
  localparam int NCHK   = 2 * T * M
) (
  input logic            clk,
  input logic            rst,
  input logic [K-1:0]    data_i,
  input logic [NCHK-1:0] flt_inj_i,
  input logic [NCHK-1:0] chk_o,
  input logic            err_o
);

  // R4/R6: whatever is routed out, it is a zero-parity code word.
  a_r4_out_parity: assert property (@(posedge clk) disable iff (rst)
    (^chk_o) == 1'b0);

  if (OUT_REG) begin : g_seq
    // R8: reset clears the registered outputs.
    a_r8_reset_clear: assert property (@(posedge clk)
      rst |=> (chk_o == '0 && !err_o));
    // R5: flag follows the parity of the injected flips, one edge later.
    a_r5_flag_parity: assert property (@(posedge clk) disable iff (rst)
      (!rst) |=> (err_o == ^$past(flt_inj_i)));
    // R6: a flagged word still carries the correct row checks.
    a_r6_row_sum: assert property (@(posedge clk) disable iff (rst)
      err_o |-> ((^chk_o[M-1:0]) == (^$past(data_i))));
  end else begin : g_cmb
    a_r5_flag_parity: assert property (@(posedge clk) disable iff (rst)
      err_o == ^flt_inj_i);
    a_r6_row_sum: assert property (@(posedge clk) disable iff (rst)
      err_o |-> ((^chk_o[M-1:0]) == (^data_i)));
    a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
      (flt_inj_i == '0) |-> !err_o);
  end

endmodule

bind ols_selfcorr_enc ols_enc_sva #(.M(M), .T(T), .OUT_REG(OUT_REG)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .data_i    (data_i),
  .flt_inj_i (flt_inj_i),
  .chk_o     (chk_o),
  .err_o     (err_o)
);

// File: tb/sim_ols_selfcorr_enc.sv
`timescale 1ns/1ps
module sim_ols_selfcorr_enc;

  localparam int M = 4;
  localparam int K = M * M;
  localparam int N = 2 * M;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [K-1:0] data = '0;
  logic [N-1:0] inj  = '0;
  logic [N-1:0] chk;
  logic         err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ols_selfcorr_enc #(.M(M), .T(1), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst(rst), .data_i(data), .flt_inj_i(inj),
    .chk_o(chk), .err_o(err)
  );

  function automatic logic [N-1:0] gold(input logic [K-1:0] d);
    logic [N-1:0] c;
    c = '0;
    for (int i = 0; i < M; i++) c[i] = ^d[i*M +: M];
    for (int j = 0; j < M; j++)
      for (int r = 0; r < M; r++) c[M+j] = c[M+j] ^ d[j + M*r];
    return c;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [N:0] act, input logic [N:0] exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge (one rising edge between).
  task automatic apply(input logic [K-1:0] d, input logic [N-1:0] m);
    @(negedge clk);
    data = d;
    inj  = m;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [N-1:0] ec, input logic ee);
    check(chk == ec && err == ee, req, {err, chk}, {ee, ec});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R8 reset", '0, 1'b0);
    rst = 1'b0;

    // R1: a single set bit reaches exactly 2 checks.
    for (int b = 0; b < K; b++) begin
      apply(K'(1) << b, '0);
      check($countones(chk) == 2 && !err, "R1 fan-out", {err, chk}, {1'b0, gold(K'(1) << b)});
    end

    // R2/R3/R4: exhaustive over each group of M bits.
    for (int g = 0; g < M; g++)
      for (int v = 0; v < (1 << M); v++) begin
        logic [K-1:0] d;
        d = K'(v) << (g*M);
        apply(d, '0);
        expect_out("R2 R3 R4 group sweep", gold(d), 1'b0);
        d = '0;
        for (int r = 0; r < M; r++) d[g + M*r] = v[r];
        apply(d, '0);
        expect_out("R2 R3 R4 column sweep", gold(d), 1'b0);
      end

    // R4: random words.
    for (int n = 0; n < 200; n++) begin
      logic [K-1:0] d;
      d = K'($urandom);
      apply(d, '0);
      expect_out("R4 random", gold(d), 1'b0);
    end

    // R5/R6: single flips on every primary bit.
    for (int q = 0; q < N; q++)
      for (int n = 0; n < 4; n++) begin
        logic [K-1:0] d;
        d = K'($urandom);
        apply(d, N'(1) << q);
        expect_out("R5 R6 single flip", gold(d), 1'b1);
      end

    // R9: stuck-at-0 and stuck-at-1 on each bit.
    for (int q = 0; q < N; q++)
      for (int sv = 0; sv < 2; sv++)
        for (int n = 0; n < 3; n++) begin
          logic [K-1:0] d;
          logic [N-1:0] g;
          logic         f;
          d = K'($urandom);
          g = gold(d);
          f = g[q] ^ sv[0];
          apply(d, N'(f) << q);
          expect_out("R9 stuck-at", g, f);
        end

    // R7: even-weight flips are not seen and pass through.
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++) begin
        logic [K-1:0] d;
        logic [N-1:0] m;
        d = K'($urandom);
        m = (N'(1) << a) | (N'(1) << b);
        apply(d, m);
        expect_out("R7 double flip", gold(d) ^ m, 1'b0);
      end

    // R8: latency, output holds until the next rising edge.
    apply(16'h0001, '0);
    @(negedge clk);
    data = 16'h8000;
    inj  = 8'h01;
    #1;
    expect_out("R8 hold before edge", gold(16'h0001), 1'b0);
    @(negedge clk);
    expect_out("R8 update after edge", gold(16'h8000), 1'b1);

    // R8: reset mid-run clears outputs.
    rst = 1'b1;
    @(negedge clk);
    expect_out("R8 reset mid-run", '0, 1'b0);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule